// File: doc/BRIEF.md
# Multi-Slot Carry Flag Merge Unit

This block keeps the single carry status bit of a core that issues several arithmetic instructions side by side in one execution set. Each issue slot reports three things: whether its instruction really executes, whether that instruction changes carry, and the carry value it produced. For a 40-bit add, that value is the carry out of bit 39. For a subtract, it is the borrow out of bit 39, with 1 meaning a borrow. For a shift or rotate, it is the last bit shifted out. Bit-manipulation operations may also produce a value.

The block picks a single writer per execution set: the qualifying slot that comes latest in program order. Slot 0 is the earliest and the highest-numbered slot is the latest. A set in which no slot qualifies leaves the stored bit as it was. A synchronous, active-high core reset clears the bit. Entry to an exception service routine also clears it, and this clear overrides any slot update in the same cycle.

The result sits in a register. It appears on the output in the cycle after the execution set retires.

Top module: `carry_merge_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `carry_q` becomes 0 after that edge, whatever the slot and exception inputs are.
- R2: A slot qualifies only when its bits in both `slot_valid` and `slot_affects` are 1. A single qualifying slot i stores `slot_carry[i]`.
- R3: When several slots qualify, the one with the highest index (latest in program order) sets `carry_q`. The values from the lower slots are ignored.
- R4: When no slot qualifies and `exc_entry` is 0, `carry_q` keeps its previous value.
- R5: `exc_entry` high at an edge makes `carry_q` read 0 after that edge, even when slots qualify in the same cycle.
- R6: The stored value is the slot's carry bit unchanged: 1 stands for a carry out of bit 39 on an add, a borrow on a subtract, or a shifted-out 1. Both values 0 and 1 must be captured.
- R7: `carry_q` is registered. Inputs presented before an edge do not change it until that edge.
- R8: A cancelled instruction (valid 0) with its affects bit set has no effect on `carry_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high core reset |
| exc_entry | input | 1 | Exception service routine begins this cycle |
| slot_valid | input | NUM_SLOTS | Per-slot instruction executes |
| slot_affects | input | NUM_SLOTS | Per-slot instruction writes carry |
| slot_carry | input | NUM_SLOTS | Per-slot carry/borrow/shifted-out value |
| carry_q | output | 1 | Stored carry bit |

## Verification
The merge is tried with a single qualifying slot at each end of the slot range, and with pairs and full sets of qualifiers whose carry values differ. These cases tell a latest-wins pick apart from an earliest-wins pick or an OR of the carries. Patterns in which only valid or only affects is set check that both bits gate the update, and that the stored bit then holds. Exception entry is applied together with slots that would write 1, which shows that the clear takes priority. A mid-cycle sample shows that the output waits for the clock edge.

// File: rtl/carry_merge_pkg.sv
package carry_merge_pkg;
   typedef enum logic [0:0] {
      SEL_RIPPLE = 1'b0,
      SEL_MASK   = 1'b1
   } cm_sel_style_e;

   localparam int unsigned CM_MAX_SLOTS = 16;
endpackage

// File: rtl/cm_slot_qualify.sv
module cm_slot_qualify #(
   parameter int unsigned NUM_SLOTS = 4
) (
   input  logic [NUM_SLOTS-1:0] valid_i,
   input  logic [NUM_SLOTS-1:0] affects_i,
   output logic [NUM_SLOTS-1:0] qual_o
);
   for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_qual
      assign qual_o[gi] = valid_i[gi] & affects_i[gi];
   end
endmodule

// File: rtl/cm_last_select.sv
module cm_last_select
   import carry_merge_pkg::*;
#(
   parameter int unsigned   NUM_SLOTS = 4,
   parameter cm_sel_style_e SEL_STYLE = SEL_MASK
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_SLOTS-1:0] qual_i,
   input  logic [NUM_SLOTS-1:0] carry_i,
   output logic [NUM_SLOTS-1:0] grant_o,
   output logic                 any_o,
   output logic                 carry_o
);
   if (SEL_STYLE == SEL_RIPPLE) begin : g_ripple
      always_comb begin
         grant_o = '0;
         for (int i = 0; i < NUM_SLOTS; i++) begin
            if (qual_i[i]) begin
               grant_o    = '0;
               grant_o[i] = 1'b1;
            end
         end
      end
   end else begin : g_mask
      for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
         if (gi == NUM_SLOTS - 1) begin : g_top
            assign grant_o[gi] = qual_i[gi];
         end else begin : g_low
            assign grant_o[gi] = qual_i[gi] & ~(|qual_i[NUM_SLOTS-1:gi+1]);
         end
      end
   end

   assign any_o   = |qual_i;
   assign carry_o = |(grant_o & carry_i);

   // R2 / R3: at most one writer, and the writer must be a qualifying slot
   a_r3_single_grant : assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant_o));
   a_r2_grant_qualified : assert property (@(posedge clk) disable iff (rst)
      (grant_o & ~qual_i) == '0);
   a_r3_some_grant : assert property (@(posedge clk) disable iff (rst)
      (qual_i != '0) |-> ($countones(grant_o) == 1));
endmodule

// File: rtl/carry_merge_unit.sv
module carry_merge_unit
   import carry_merge_pkg::*;
#(
   parameter int unsigned   NUM_SLOTS = 4,
   parameter cm_sel_style_e SEL_STYLE = SEL_MASK
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 exc_entry,
   input  logic [NUM_SLOTS-1:0] slot_valid,
   input  logic [NUM_SLOTS-1:0] slot_affects,
   input  logic [NUM_SLOTS-1:0] slot_carry,
   output logic                 carry_q
);
   localparam int unsigned LAST = NUM_SLOTS - 1;

   if (NUM_SLOTS < 1 || NUM_SLOTS > CM_MAX_SLOTS) begin : g_bad_slots
      $error("carry_merge_unit: NUM_SLOTS out of range");
   end

   logic [NUM_SLOTS-1:0] qual;
   logic [NUM_SLOTS-1:0] grant;
   logic                 any_wr;
   logic                 win_carry;
   logic                 carry_d;

   cm_slot_qualify #(.NUM_SLOTS(NUM_SLOTS)) u_qual (
      .valid_i   (slot_valid),
      .affects_i (slot_affects),
      .qual_o    (qual)
   );

   cm_last_select #(.NUM_SLOTS(NUM_SLOTS), .SEL_STYLE(SEL_STYLE)) u_sel (
      .clk     (clk),
      .rst     (rst),
      .qual_i  (qual),
      .carry_i (slot_carry),
      .grant_o (grant),
      .any_o   (any_wr),
      .carry_o (win_carry)
   );

   always_comb begin
      if (exc_entry)   carry_d = 1'b0;
      else if (any_wr) carry_d = win_carry;
      else             carry_d = carry_q;
   end

   always_ff @(posedge clk) begin
      if (rst) carry_q <= 1'b0;
      else     carry_q <= carry_d;
   end

   // R1: reset clears the bit
   a_r1_reset_clear : assert property (@(posedge clk)
      rst |=> !carry_q);
   // R5: exception entry wins over any slot
   a_r5_exc_clear : assert property (@(posedge clk) disable iff (rst)
      exc_entry |=> !carry_q);
   // R4 / R8: no qualifying slot holds the bit
   a_r4_hold : assert property (@(posedge clk) disable iff (rst)
      (!exc_entry && ((slot_valid & slot_affects) == '0)) |=> $stable(carry_q));
   // R3: latest slot decides whenever it qualifies
   a_r3_last_wins : assert property (@(posedge clk) disable iff (rst)
      (!exc_entry && slot_valid[LAST] && slot_affects[LAST])
         |=> (carry_q == $past(slot_carry[LAST])));
   // R2: the stored value always comes from one of the slots when written
   a_r2_from_slot : assert property (@(posedge clk) disable iff (rst)
      (!exc_entry && ((slot_valid & slot_affects & slot_carry) == '0)
                  && ((slot_valid & slot_affects) != '0)) |=> !carry_q);
endmodule

// File: tb/carry_merge_unit_bench.sv
module carry_merge_unit_bench;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         exc_entry = 1'b0;
   logic [N-1:0] slot_valid = '0;
   logic [N-1:0] slot_affects = '0;
   logic [N-1:0] slot_carry = '0;
   logic         carry_q;

   int vectors = 0;
   int misses  = 0;
   logic model = 1'b0;
   bit   done  = 1'b0;

   always #10 clk = ~clk;

   carry_merge_unit #(.NUM_SLOTS(N)) u_carry_merge_unit (
      .clk(clk), .rst(rst), .exc_entry(exc_entry),
      .slot_valid(slot_valid), .slot_affects(slot_affects),
      .slot_carry(slot_carry), .carry_q(carry_q)
   );

   // fields: {exc, valid[3:0], affects[3:0], carry[3:0]}
   localparam logic [12:0] VEC [16] = '{
      13'b0_0001_0001_0001,
      13'b0_0000_1111_0000,
      13'b0_1111_0000_0000,
      13'b0_0011_0011_0001,
      13'b0_1111_1111_1000,
      13'b0_1111_0111_1011,
      13'b0_0101_1111_0100,
      13'b0_0111_1101_0010,
      13'b0_1000_1000_1000,
      13'b1_1111_1111_1111,
      13'b0_0010_0010_0010,
      13'b1_0000_0000_0000,
      13'b0_0000_0000_0000,
      13'b0_0100_0100_0100,
      13'b0_0110_0110_0010,
      13'b0_1001_0001_0001
   };

   task automatic check(input logic exp, input string req);
      vectors++;
      if (carry_q !== exp) begin
         misses++;
         $display("FAIL %s: carry_q=%b expected %b", req, carry_q, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      misses++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(1'b0, "R1");                  // reset state
      rst = 1'b0;

      for (int k = 0; k < 16; k++) begin
         logic [N-1:0] q;
         string tag;
         logic e;
         e            = VEC[k][12];
         slot_valid   = VEC[k][11:8];
         slot_affects = VEC[k][7:4];
         slot_carry   = VEC[k][3:0];
         exc_entry    = e;
         q = slot_valid & slot_affects;
         if (e) begin
            model = 1'b0; tag = "R5";
         end else if (q == '0) begin
            tag = ((slot_affects & ~slot_valid) != '0) ? "R8" : "R4";
         end else begin
            for (int i = 0; i < N; i++) if (q[i]) model = slot_carry[i];
            tag = ($countones(q) > 1) ? "R3" : ((k >= 13) ? "R6" : "R2");
         end
         @(negedge clk);
         check(model, tag);
      end

      // R7: output waits for the edge
      exc_entry = 1'b0;
      slot_valid = 4'b1000; slot_affects = 4'b1000; slot_carry = 4'b0000;
      @(negedge clk); model = 1'b0;
      check(model, "R6");
      slot_carry = 4'b1000;
      #5 check(1'b0, "R7");
      @(negedge clk);
      check(1'b1, "R7");

      // R1: reset overrides a writing slot
      rst = 1'b1;
      @(negedge clk);
      check(1'b0, "R1");
      rst = 1'b0;
      slot_valid = '0; slot_affects = '0;
      @(negedge clk);
      check(1'b0, "R4");

      finish_run();
   end
endmodule